// File: doc/BRIEF.md
# Load/Store Cache Request Controller

This block stands between the memory stage of a pipelined processor and its data cache. Each cycle it may accept one memory operation: a load, a store, a load-linked, a store-conditional or a prefetch. From the operation kind it forms the cache request: shared or exclusive, with or without the atomic flavor tag, or no request at all. It then turns the cache's same-cycle answer (hit, busy, miss or conditional failure) into a registered outcome for the pipeline: done, retry or wait.

Per request tag it keeps a set of status flags and the miss identifier returned by the cache. A tag whose miss is still outstanding is re-presented without a new cache request. Per register pair it keeps two reason slots that explain why a load's destination is not yet available. It also owns the link bit that pairs a load-linked with a later store-conditional. A store-conditional that finds the bit clear fails at once, without touching the cache.

Top module: `lsc_ctrl`

## Requirements
- R1: A prefetch with a hint value of 1, 5 or 7 requests the line exclusive (`cache_excl`=1). Every other hint value requests it shared. Prefetches assert `cache_prefetch`.
- R2: A prefetch with `req_addr_ok`=0 raises no cache request. Every prefetch answers done (`rsp_status`=0) on the next cycle, and its tag's flags show only done (`stat_flags`=5'b00001).
- R3: A store-conditional presented while `link_bit`=0 raises no cache request. One cycle later it reports done, writes 0 to `req_res_reg` (`rsp_wr_en`=1, `rsp_wr_val`=0) and sets `rsp_size_zero`.
- R4: Loads and load-linked operations request shared. Stores and store-conditionals request exclusive. Only load-linked and store-conditional assert `cache_atomic`.
- R5: On a hit the tag is marked cached. If `req_pend`=0 the access is performed and reported done. If `req_pend`=1 the outcome is wait (`rsp_status`=2), and pending is marked instead of done.
- R6: On a busy answer the outcome is retry (`rsp_status`=1) and the tag is marked failed. A load or load-linked records reason busy (code 1) for its register pair.
- R7: On a miss the tag is marked stalled and cached, and `cache_miss_id` is saved and reported. Plain stores, and loads with `req_wb_hit`=1, are still performed and reported done. Other operations wait. Any load records reason bus wait (code 2).
- R8: Re-presenting a tag whose stalled flag is set raises no cache request. It reports wait with the saved miss identifier.
- R9: A performed load-linked sets `link_bit` one cycle later. `link_clr` clears it. Reset clears it.
- R10: A performed store-conditional writes 1 to its result register. A conditional-failure answer writes 0, sets `rsp_size_zero` and reports done.
- R11: A reason goes to the register pair at index `req_dst`>>1. If that pair's next slot holds 0 (empty), the reason is written into the current slot; otherwise it overwrites the next slot. `why_arm_*` writes the next slot.
- R12: `alloc_valid` clears every flag and the miss identifier of `alloc_tag`. The encoding of `stat_flags` is {stall, cached, pend, failed, done}, from bit 4 down to bit 0.
- R13: After reset `rsp_valid`=0 and all flags and reasons are 0. The op encoding is load=0, store=1, load-linked=2, store-conditional=3, prefetch=4. The cache answer encoding is hit=0, busy=1, miss=2, conditional failure=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation presented this cycle |
| req_tag | input | TAG_W | Request tag of the operation |
| req_op | input | 3 | Operation kind |
| req_hint | input | HINT_W | Prefetch hint |
| req_addr_ok | input | 1 | Physical address is valid |
| req_dst | input | REG_W | Destination register of a load |
| req_res_reg | input | REG_W | Result register of a store-conditional |
| req_wb_hit | input | 1 | Load is satisfied by the write buffer |
| req_pend | input | 1 | Operation data still pending |
| cache_req_valid | output | 1 | Cache request issued |
| cache_excl | output | 1 | Request asks for ownership |
| cache_atomic | output | 1 | Request carries the atomic flavor |
| cache_prefetch | output | 1 | Request is a prefetch |
| cache_rsp | input | 2 | Cache answer, same cycle |
| cache_miss_id | input | MISS_W | Miss identifier from the cache |
| alloc_valid | input | 1 | Allocate a tag |
| alloc_tag | input | TAG_W | Tag being allocated |
| link_clr | input | 1 | Clear the link bit |
| why_arm_valid | input | 1 | Write a register pair's next slot |
| why_arm_idx | input | REG_W-1 | Register pair index to write |
| why_arm_code | input | 2 | Reason code to write |
| stat_tag | input | TAG_W | Tag to read status for |
| stat_flags | output | 5 | Flags of `stat_tag` |
| stat_miss_id | output | MISS_W | Saved miss id of `stat_tag` |
| why_idx | input | REG_W-1 | Register pair index to read |
| why_cur | output | 2 | Current reason of `why_idx` |
| why_next | output | 2 | Next reason of `why_idx` |
| rsp_valid | output | 1 | Outcome valid |
| rsp_tag | output | TAG_W | Tag of the outcome |
| rsp_status | output | 2 | 0 done, 1 retry, 2 wait |
| rsp_perform | output | 1 | Access was performed |
| rsp_wr_en | output | 1 | Conditional result write |
| rsp_wr_reg | output | REG_W | Result register |
| rsp_wr_val | output | 1 | Result value |
| rsp_size_zero | output | 1 | Store size forced to zero |
| rsp_miss_id | output | MISS_W | Miss id tied to the outcome |
| link_bit | output | 1 | Current link bit |

## Verification
The bench builds the block with a 3-bit hint, so all eight hint values of the prefetch mapping are swept, and the exclusive mask is passed as an 8-bit value. It uses a 2-bit tag, so the four tags are reused and re-allocation must be seen to wipe a stalled tag. The register and miss-identifier widths stay at their defaults. These widths let the reason table's register-pair folding (registers 16 and 17 share pair 8) and the overwrite of an armed next slot be observed directly.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_LL    = 3'd2,
        OP_SC    = 3'd3,
        OP_PREF  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        CR_HIT    = 2'd0,
        CR_BUSY   = 2'd1,
        CR_MISS   = 2'd2,
        CR_SCFAIL = 2'd3
    } crsp_e;

    typedef enum logic [1:0] {
        RS_DONE  = 2'd0,
        RS_RETRY = 2'd1,
        RS_WAIT  = 2'd2,
        RS_NONE  = 2'd3
    } rstat_e;

    localparam logic [1:0] WHY_NONE = 2'd0;
    localparam logic [1:0] WHY_BUSY = 2'd1;
    localparam logic [1:0] WHY_BUS  = 2'd2;

    typedef struct packed {
        logic stall;
        logic cached;
        logic pend;
        logic failed;
        logic done;
    } flags_t;

endpackage

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
#(
    parameter int HINT_W = 5,
    parameter logic [(1<<HINT_W)-1:0] EXCL_HINT_MASK = 'hA2
) (
    input  logic              req_valid,
    input  op_e               op,
    input  logic [HINT_W-1:0] hint,
    input  logic              addr_ok,
    input  logic              link_bit,
    input  logic              stalled,
    output logic              cache_req_valid,
    output logic              cache_excl,
    output logic              cache_atomic,
    output logic              cache_prefetch,
    output logic              sc_early_fail
);

    logic is_pf;
    logic is_atomic;
    logic wants_own;

    always_comb begin
        is_pf     = (op == OP_PREF);
        is_atomic = (op == OP_LL) || (op == OP_SC);
        wants_own = (op == OP_STORE) || (op == OP_SC);

        // conditional store without a live link never reaches the cache
        sc_early_fail = req_valid && (op == OP_SC) && !link_bit;

        if (is_pf) begin
            cache_req_valid = req_valid && addr_ok;
            cache_excl      = EXCL_HINT_MASK[hint];
        end else begin
            cache_req_valid = req_valid && !sc_early_fail && !stalled;
            cache_excl      = wants_own;
        end
        cache_atomic   = !is_pf && is_atomic;
        cache_prefetch = is_pf;
    end

endmodule

// File: rtl/lsc_resolve.sv
module lsc_resolve
    import lsc_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int MISS_W = 6,
    localparam int IDX_W = REG_W - 1
) (
    input  logic              req_valid,
    input  op_e               op,
    input  logic [REG_W-1:0]  dst,
    input  logic [REG_W-1:0]  res_reg,
    input  logic              wb_hit,
    input  logic              pend,
    input  logic              sc_early_fail,
    input  logic              stalled,
    input  crsp_e             crsp,
    input  logic [MISS_W-1:0] miss_id,
    input  logic [MISS_W-1:0] saved_miss,
    // outcome
    output rstat_e            o_status,
    output logic              o_perform,
    output logic              o_wr_en,
    output logic [REG_W-1:0]  o_wr_reg,
    output logic              o_wr_val,
    output logic              o_size_zero,
    output logic [MISS_W-1:0] o_miss_id,
    // flag update
    output logic              upd_en,
    output flags_t            set_bits,
    output logic              save_miss,
    // reason update
    output logic              why_en,
    output logic [IDX_W-1:0]  why_idx,
    output logic [1:0]        why_code,
    // link
    output logic              link_set
);

    logic is_ld;

    always_comb begin
        is_ld       = (op == OP_LOAD) || (op == OP_LL);
        o_status    = RS_NONE;
        o_perform   = 1'b0;
        o_wr_en     = 1'b0;
        o_wr_reg    = res_reg;
        o_wr_val    = 1'b0;
        o_size_zero = 1'b0;
        o_miss_id   = '0;
        upd_en      = 1'b0;
        set_bits    = '0;
        save_miss   = 1'b0;
        why_en      = 1'b0;
        why_idx     = dst[REG_W-1:1];
        why_code    = WHY_NONE;
        link_set    = 1'b0;

        if (req_valid) begin
            upd_en = 1'b1;
            if (op == OP_PREF) begin
                o_status      = RS_DONE;
                set_bits.done = 1'b1;
            end else if (sc_early_fail) begin
                o_status      = RS_DONE;
                o_wr_en       = 1'b1;
                o_size_zero   = 1'b1;
                set_bits.done = 1'b1;
            end else if (stalled) begin
                o_status  = RS_WAIT;
                o_miss_id = saved_miss;
                upd_en    = 1'b0;
            end else begin
                unique case (crsp)
                    CR_HIT: begin
                        set_bits.cached = 1'b1;
                        if (pend) begin
                            set_bits.pend = 1'b1;
                            o_status      = RS_WAIT;
                        end else begin
                            o_perform     = 1'b1;
                            set_bits.done = 1'b1;
                            o_status      = RS_DONE;
                        end
                    end
                    CR_BUSY: begin
                        set_bits.failed = 1'b1;
                        o_status        = RS_RETRY;
                        if (is_ld) begin
                            why_en   = 1'b1;
                            why_code = WHY_BUSY;
                        end
                    end
                    CR_MISS: begin
                        set_bits.stall  = 1'b1;
                        set_bits.cached = 1'b1;
                        save_miss       = 1'b1;
                        o_miss_id       = miss_id;
                        o_status        = RS_WAIT;
                        if (pend) begin
                            set_bits.pend = 1'b1;
                        end else begin
                            if ((op == OP_STORE) || (is_ld && wb_hit)) begin
                                o_perform     = 1'b1;
                                set_bits.done = 1'b1;
                                o_status      = RS_DONE;
                            end
                            if (is_ld) begin
                                why_en   = 1'b1;
                                why_code = WHY_BUS;
                            end
                        end
                    end
                    default: begin
                        o_status      = RS_DONE;
                        o_wr_en       = 1'b1;
                        o_size_zero   = 1'b1;
                        set_bits.done = 1'b1;
                    end
                endcase
                if (o_perform && (op == OP_LL)) begin
                    link_set = 1'b1;
                end
                if (o_perform && (op == OP_SC)) begin
                    o_wr_en  = 1'b1;
                    o_wr_val = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lsc_status.sv
module lsc_status
    import lsc_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int MISS_W = 6,
    localparam int NTAG  = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [TAG_W-1:0]  upd_tag,
    input  flags_t            set_bits,
    input  logic              save_miss,
    input  logic [MISS_W-1:0] miss_in,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [TAG_W-1:0]  rd_tag,
    output flags_t            rd_flags,
    output logic [MISS_W-1:0] rd_miss,
    output logic              req_stalled,
    output logic [MISS_W-1:0] req_miss
);

    typedef struct packed {
        flags_t [NTAG-1:0]             fl;
        logic   [NTAG-1:0][MISS_W-1:0] ms;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.fl[upd_tag] = flags_t'(st_q.fl[upd_tag] | set_bits);
            if (save_miss) begin
                st_d.ms[upd_tag] = miss_in;
            end
        end
        if (alloc_valid) begin
            st_d.fl[alloc_tag] = '0;
            st_d.ms[alloc_tag] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_flags    = st_q.fl[rd_tag];
    assign rd_miss     = st_q.ms[rd_tag];
    assign req_stalled = st_q.fl[upd_tag].stall;
    assign req_miss    = st_q.ms[upd_tag];

endmodule

// File: rtl/lsc_reason.sv
module lsc_reason #(
    parameter int REG_W  = 5,
    localparam int IDX_W = REG_W - 1,
    localparam int NIDX  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_valid,
    input  logic [IDX_W-1:0] arm_idx,
    input  logic [1:0]       arm_code,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [1:0]       upd_code,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_cur,
    output logic [1:0]       rd_next
);

    typedef struct packed {
        logic [NIDX-1:0][1:0] cur;
        logic [NIDX-1:0][1:0] nxt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_valid) begin
            st_d.nxt[arm_idx] = arm_code;
        end
        if (upd_en) begin
            if (st_q.nxt[upd_idx] == 2'd0) begin
                st_d.cur[upd_idx] = upd_code;
            end else begin
                st_d.nxt[upd_idx] = upd_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_cur  = st_q.cur[rd_idx];
    assign rd_next = st_q.nxt[rd_idx];

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
    import lsc_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int REG_W  = 5,
    parameter int HINT_W = 5,
    parameter int MISS_W = 6,
    parameter logic [(1<<HINT_W)-1:0] EXCL_HINT_MASK = 'hA2,
    localparam int IDX_W = REG_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [2:0]        req_op,
    input  logic [HINT_W-1:0] req_hint,
    input  logic              req_addr_ok,
    input  logic [REG_W-1:0]  req_dst,
    input  logic [REG_W-1:0]  req_res_reg,
    input  logic              req_wb_hit,
    input  logic              req_pend,
    output logic              cache_req_valid,
    output logic              cache_excl,
    output logic              cache_atomic,
    output logic              cache_prefetch,
    input  logic [1:0]        cache_rsp,
    input  logic [MISS_W-1:0] cache_miss_id,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              link_clr,
    input  logic              why_arm_valid,
    input  logic [IDX_W-1:0]  why_arm_idx,
    input  logic [1:0]        why_arm_code,
    input  logic [TAG_W-1:0]  stat_tag,
    output logic [4:0]        stat_flags,
    output logic [MISS_W-1:0] stat_miss_id,
    input  logic [IDX_W-1:0]  why_idx,
    output logic [1:0]        why_cur,
    output logic [1:0]        why_next,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_status,
    output logic              rsp_perform,
    output logic              rsp_wr_en,
    output logic [REG_W-1:0]  rsp_wr_reg,
    output logic              rsp_wr_val,
    output logic              rsp_size_zero,
    output logic [MISS_W-1:0] rsp_miss_id,
    output logic              link_bit
);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        rstat_e            status;
        logic              perform;
        logic              wr_en;
        logic [REG_W-1:0]  wr_reg;
        logic              wr_val;
        logic              size_zero;
        logic [MISS_W-1:0] miss_id;
    } resp_t;

    typedef struct packed {
        resp_t rsp;
        logic  link;
    } state_t;

    state_t st_d, st_q;

    op_e               op;
    crsp_e             crsp;
    logic              stalled;
    logic [MISS_W-1:0] saved_miss;
    logic              sc_early_fail;

    rstat_e            r_status;
    logic              r_perform, r_wr_en, r_wr_val, r_size_zero;
    logic [REG_W-1:0]  r_wr_reg;
    logic [MISS_W-1:0] r_miss_id;
    logic              upd_en, save_miss, why_en, link_set;
    flags_t            set_bits, rd_flags;
    logic [IDX_W-1:0]  why_upd_idx;
    logic [1:0]        why_upd_code;

    assign op   = op_e'(req_op);
    assign crsp = crsp_e'(cache_rsp);

    lsc_decode #(
        .HINT_W        (HINT_W),
        .EXCL_HINT_MASK(EXCL_HINT_MASK)
    ) i_decode (
        .req_valid      (req_valid),
        .op             (op),
        .hint           (req_hint),
        .addr_ok        (req_addr_ok),
        .link_bit       (st_q.link),
        .stalled        (stalled),
        .cache_req_valid(cache_req_valid),
        .cache_excl     (cache_excl),
        .cache_atomic   (cache_atomic),
        .cache_prefetch (cache_prefetch),
        .sc_early_fail  (sc_early_fail)
    );

    lsc_resolve #(
        .REG_W (REG_W),
        .MISS_W(MISS_W)
    ) i_resolve (
        .req_valid    (req_valid),
        .op           (op),
        .dst          (req_dst),
        .res_reg      (req_res_reg),
        .wb_hit       (req_wb_hit),
        .pend         (req_pend),
        .sc_early_fail(sc_early_fail),
        .stalled      (stalled),
        .crsp         (crsp),
        .miss_id      (cache_miss_id),
        .saved_miss   (saved_miss),
        .o_status     (r_status),
        .o_perform    (r_perform),
        .o_wr_en      (r_wr_en),
        .o_wr_reg     (r_wr_reg),
        .o_wr_val     (r_wr_val),
        .o_size_zero  (r_size_zero),
        .o_miss_id    (r_miss_id),
        .upd_en       (upd_en),
        .set_bits     (set_bits),
        .save_miss    (save_miss),
        .why_en       (why_en),
        .why_idx      (why_upd_idx),
        .why_code     (why_upd_code),
        .link_set     (link_set)
    );

    lsc_status #(
        .TAG_W (TAG_W),
        .MISS_W(MISS_W)
    ) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .upd_tag    (req_tag),
        .set_bits   (set_bits),
        .save_miss  (save_miss),
        .miss_in    (cache_miss_id),
        .alloc_valid(alloc_valid),
        .alloc_tag  (alloc_tag),
        .rd_tag     (stat_tag),
        .rd_flags   (rd_flags),
        .rd_miss    (stat_miss_id),
        .req_stalled(stalled),
        .req_miss   (saved_miss)
    );

    lsc_reason #(
        .REG_W(REG_W)
    ) i_reason (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_valid(why_arm_valid),
        .arm_idx  (why_arm_idx),
        .arm_code (why_arm_code),
        .upd_en   (why_en),
        .upd_idx  (why_upd_idx),
        .upd_code (why_upd_code),
        .rd_idx   (why_idx),
        .rd_cur   (why_cur),
        .rd_next  (why_next)
    );

    always_comb begin
        st_d               = st_q;
        st_d.rsp.valid     = req_valid;
        st_d.rsp.tag       = req_tag;
        st_d.rsp.status    = r_status;
        st_d.rsp.perform   = r_perform;
        st_d.rsp.wr_en     = r_wr_en;
        st_d.rsp.wr_reg    = r_wr_reg;
        st_d.rsp.wr_val    = r_wr_val;
        st_d.rsp.size_zero = r_size_zero;
        st_d.rsp.miss_id   = r_miss_id;
        if (link_clr) begin
            st_d.link = 1'b0;
        end else if (link_set) begin
            st_d.link = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.rsp.status <= RS_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_flags    = rd_flags;
    assign rsp_valid     = st_q.rsp.valid;
    assign rsp_tag       = st_q.rsp.tag;
    assign rsp_status    = st_q.rsp.status;
    assign rsp_perform   = st_q.rsp.perform;
    assign rsp_wr_en     = st_q.rsp.wr_en;
    assign rsp_wr_reg    = st_q.rsp.wr_reg;
    assign rsp_wr_val    = st_q.rsp.wr_val;
    assign rsp_size_zero = st_q.rsp.size_zero;
    assign rsp_miss_id   = st_q.rsp.miss_id;
    assign link_bit      = st_q.link;

endmodule

// File: rtl/lsc_ctrl_chk.sv
module lsc_ctrl_chk #(
    parameter int HINT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [HINT_W-1:0] req_hint,
    input logic              req_addr_ok,
    input logic              cache_req_valid,
    input logic              cache_excl,
    input logic              cache_atomic,
    input logic [1:0]        cache_rsp,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic              rsp_wr_en,
    input logic              rsp_wr_val,
    input logic              rsp_size_zero,
    input logic              link_bit
);

    a_r1_pf_owner_hint: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4 && req_addr_ok &&
         (req_hint == 1 || req_hint == 5 || req_hint == 7))
        |-> (cache_req_valid && cache_excl));

    a_r2_pf_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> (rsp_valid && rsp_status == 2'd0));

    a_r3_sc_no_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && !link_bit) |-> !cache_req_valid);

    a_r3_sc_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && !link_bit)
        |=> (rsp_wr_en && !rsp_wr_val && rsp_size_zero));

    a_r4_load_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd0 && cache_req_valid)
        |-> (!cache_excl && !cache_atomic));

    a_r6_busy_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 3'd4 && cache_req_valid && cache_rsp == 2'd1)
        |=> (rsp_status == 2'd1));

    a_r9_link_from_ll: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_bit) |-> $past(req_valid && req_op == 3'd2));

endmodule

bind lsc_ctrl lsc_ctrl_chk #(.HINT_W(HINT_W)) i_lsc_ctrl_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_hint       (req_hint),
    .req_addr_ok    (req_addr_ok),
    .cache_req_valid(cache_req_valid),
    .cache_excl     (cache_excl),
    .cache_atomic   (cache_atomic),
    .cache_rsp      (cache_rsp),
    .rsp_valid      (rsp_valid),
    .rsp_status     (rsp_status),
    .rsp_wr_en      (rsp_wr_en),
    .rsp_wr_val     (rsp_wr_val),
    .rsp_size_zero  (rsp_size_zero),
    .link_bit       (link_bit)
);

// File: tb/test_lsc_ctrl.sv
`timescale 1ns/1ps
module test_lsc_ctrl;

    localparam int TAG_W  = 2;
    localparam int REG_W  = 5;
    localparam int HINT_W = 3;
    localparam int MISS_W = 6;
    localparam int IDX_W  = REG_W - 1;

    localparam int LD = 0, ST = 1, LL = 2, SC = 3, PF = 4;
    localparam int HIT = 0, BUSY = 1, MISS = 2, SCF = 3;
    localparam int DONE = 0, RETRY = 1, WAIT = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [2:0]        req_op = '0;
    logic [HINT_W-1:0] req_hint = '0;
    logic              req_addr_ok = 1'b0;
    logic [REG_W-1:0]  req_dst = '0;
    logic [REG_W-1:0]  req_res_reg = '0;
    logic              req_wb_hit = 1'b0;
    logic              req_pend = 1'b0;
    logic              cache_req_valid, cache_excl, cache_atomic, cache_prefetch;
    logic [1:0]        cache_rsp = '0;
    logic [MISS_W-1:0] cache_miss_id = '0;
    logic              alloc_valid = 1'b0;
    logic [TAG_W-1:0]  alloc_tag = '0;
    logic              link_clr = 1'b0;
    logic              why_arm_valid = 1'b0;
    logic [IDX_W-1:0]  why_arm_idx = '0;
    logic [1:0]        why_arm_code = '0;
    logic [TAG_W-1:0]  stat_tag = '0;
    logic [4:0]        stat_flags;
    logic [MISS_W-1:0] stat_miss_id;
    logic [IDX_W-1:0]  why_idx = '0;
    logic [1:0]        why_cur, why_next;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic [1:0]        rsp_status;
    logic              rsp_perform, rsp_wr_en, rsp_wr_val, rsp_size_zero;
    logic [REG_W-1:0]  rsp_wr_reg;
    logic [MISS_W-1:0] rsp_miss_id;
    logic              link_bit;

    int checks = 0;
    int errors = 0;
    logic c_v, c_x, c_a, c_p;

    always #4 clk = ~clk;

    lsc_ctrl #(
        .TAG_W(TAG_W), .REG_W(REG_W), .HINT_W(HINT_W), .MISS_W(MISS_W),
        .EXCL_HINT_MASK(8'hA2)
    ) i_lsc_ctrl (.*);

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic send(input int op, input int tag, input int dst, input int res,
                        input int hint, input int aok, input int wbh, input int pnd,
                        input int crsp, input int mid);
        req_valid = 1'b1; req_op = op[2:0]; req_tag = tag[TAG_W-1:0];
        req_dst = dst[REG_W-1:0]; req_res_reg = res[REG_W-1:0];
        req_hint = hint[HINT_W-1:0]; req_addr_ok = aok[0]; req_wb_hit = wbh[0];
        req_pend = pnd[0]; cache_rsp = crsp[1:0]; cache_miss_id = mid[MISS_W-1:0];
        #1;
        c_v = cache_req_valid; c_x = cache_excl; c_a = cache_atomic; c_p = cache_prefetch;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic alloc(input int tag);
        alloc_valid = 1'b1; alloc_tag = tag[TAG_W-1:0];
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic arm(input int idx, input int code);
        why_arm_valid = 1'b1; why_arm_idx = idx[IDX_W-1:0]; why_arm_code = code[1:0];
        @(negedge clk);
        why_arm_valid = 1'b0;
    endtask

    task automatic flags_of(input int tag, input int exp, input string rq);
        stat_tag = tag[TAG_W-1:0];
        #1;
        chk(rq, int'(stat_flags), exp);
    endtask

    task automatic why_of(input int idx, input int ecur, input int enxt, input string rq);
        why_idx = idx[IDX_W-1:0];
        #1;
        chk({rq, " cur"}, int'(why_cur), ecur);
        chk({rq, " next"}, int'(why_next), enxt);
    endtask

    task automatic t_reset();
        chk("R13 rsp_valid", int'(rsp_valid), 0);
        chk("R9 link reset", int'(link_bit), 0);
        flags_of(0, 0, "R13 flags");
        why_of(0, 0, 0, "R13 reason");
    endtask

    task automatic t_prefetch();
        for (int h = 0; h < 8; h++) begin
            send(PF, 1, 0, 0, h, 1, 0, 0, HIT, 0);
            chk("R1 req", int'(c_v), 1);
            chk("R1 excl", int'(c_x), (h == 1 || h == 5 || h == 7) ? 1 : 0);
            chk("R1 pf", int'(c_p), 1);
            chk("R2 done", int'(rsp_status), DONE);
        end
        alloc(1);
        send(PF, 1, 0, 0, 5, 0, 0, 0, MISS, 9);
        chk("R2 no req", int'(c_v), 0);
        chk("R2 done", int'(rsp_status), DONE);
        flags_of(1, 5'b00001, "R2 flags");
    endtask

    task automatic t_sc_nolink();
        alloc(2);
        send(SC, 2, 0, 7, 0, 1, 0, 0, HIT, 0);
        chk("R3 no req", int'(c_v), 0);
        chk("R3 status", int'(rsp_status), DONE);
        chk("R3 wr_en", int'(rsp_wr_en), 1);
        chk("R3 wr_reg", int'(rsp_wr_reg), 7);
        chk("R3 wr_val", int'(rsp_wr_val), 0);
        chk("R3 size0", int'(rsp_size_zero), 1);
        chk("R3 link", int'(link_bit), 0);
    endtask

    task automatic t_classes();
        alloc(0);
        send(LD, 0, 4, 0, 0, 1, 0, 0, HIT, 0);
        chk("R4 ld req", int'(c_v), 1);
        chk("R4 ld excl", int'(c_x), 0);
        chk("R4 ld atomic", int'(c_a), 0);
        chk("R5 hit done", int'(rsp_status), DONE);
        chk("R5 perform", int'(rsp_perform), 1);
        flags_of(0, 5'b01001, "R5 hit flags");
        alloc(3);
        send(ST, 3, 0, 0, 0, 1, 0, 0, HIT, 0);
        chk("R4 st excl", int'(c_x), 1);
        chk("R4 st atomic", int'(c_a), 0);
        alloc(0);
        send(LL, 0, 6, 0, 0, 1, 0, 0, HIT, 0);
        chk("R4 ll excl", int'(c_x), 0);
        chk("R4 ll atomic", int'(c_a), 1);
        chk("R9 link set", int'(link_bit), 1);
        alloc(2);
        send(SC, 2, 0, 9, 0, 1, 0, 0, HIT, 0);
        chk("R4 sc excl", int'(c_x), 1);
        chk("R4 sc atomic", int'(c_a), 1);
        chk("R10 sc wr", int'(rsp_wr_en), 1);
        chk("R10 sc reg", int'(rsp_wr_reg), 9);
        chk("R10 sc val", int'(rsp_wr_val), 1);
    endtask

    task automatic t_pend();
        alloc(1);
        send(LD, 1, 2, 0, 0, 1, 0, 1, HIT, 0);
        chk("R5 pend wait", int'(rsp_status), WAIT);
        chk("R5 pend perform", int'(rsp_perform), 0);
        flags_of(1, 5'b01100, "R5 pend flags");
    endtask

    task automatic t_busy();
        alloc(3);
        send(LD, 3, 10, 0, 0, 1, 0, 0, BUSY, 0);
        chk("R6 retry", int'(rsp_status), RETRY);
        flags_of(3, 5'b00010, "R6 flags");
        why_of(5, 1, 0, "R6 reason");
        alloc(0);
        send(ST, 0, 12, 0, 0, 1, 0, 0, BUSY, 0);
        chk("R6 st retry", int'(rsp_status), RETRY);
        why_of(6, 0, 0, "R6 store no reason");
    endtask

    task automatic t_miss();
        alloc(0);
        send(ST, 0, 0, 0, 0, 1, 0, 0, MISS, 42);
        chk("R7 st done", int'(rsp_status), DONE);
        chk("R7 st perform", int'(rsp_perform), 1);
        chk("R7 miss id", int'(rsp_miss_id), 42);
        flags_of(0, 5'b11001, "R7 st flags");
        chk("R7 saved id", int'(stat_miss_id), 42);
        alloc(1);
        send(LD, 1, 12, 0, 0, 1, 0, 0, MISS, 21);
        chk("R7 ld wait", int'(rsp_status), WAIT);
        chk("R7 ld perform", int'(rsp_perform), 0);
        flags_of(1, 5'b11000, "R7 ld flags");
        why_of(6, 2, 0, "R7 reason");
        alloc(2);
        send(LD, 2, 14, 0, 0, 1, 1, 0, MISS, 5);
        chk("R7 wb done", int'(rsp_status), DONE);
        chk("R7 wb perform", int'(rsp_perform), 1);
        why_of(7, 2, 0, "R7 wb reason");
        alloc(3);
        send(SC, 3, 0, 4, 0, 1, 0, 0, MISS, 7);
        chk("R7 sc wait", int'(rsp_status), WAIT);
        chk("R7 sc no wr", int'(rsp_wr_en), 0);
    endtask

    task automatic t_stalled();
        send(LD, 1, 12, 0, 0, 1, 0, 0, HIT, 3);
        chk("R8 no req", int'(c_v), 0);
        chk("R8 wait", int'(rsp_status), WAIT);
        chk("R8 saved id", int'(rsp_miss_id), 21);
        flags_of(1, 5'b11000, "R8 flags kept");
    endtask

    task automatic t_scfail();
        chk("R10 link live", int'(link_bit), 1);
        alloc(2);
        send(SC, 2, 0, 3, 0, 1, 0, 0, SCF, 0);
        chk("R10 req", int'(c_v), 1);
        chk("R10 done", int'(rsp_status), DONE);
        chk("R10 wr", int'(rsp_wr_en), 1);
        chk("R10 val", int'(rsp_wr_val), 0);
        chk("R10 size0", int'(rsp_size_zero), 1);
    endtask

    task automatic t_reason();
        arm(8, 2);
        why_of(8, 0, 2, "R11 armed");
        alloc(0);
        send(LD, 0, 17, 0, 0, 1, 0, 0, BUSY, 0);
        why_of(8, 0, 1, "R11 overwrite next");
        arm(8, 0);
        alloc(0);
        send(LD, 0, 16, 0, 0, 1, 0, 0, MISS, 1);
        why_of(8, 2, 0, "R11 write cur");
    endtask

    task automatic t_alloc();
        flags_of(1, 5'b11000, "R12 before");
        alloc(1);
        flags_of(1, 0, "R12 cleared");
        chk("R12 miss cleared", int'(stat_miss_id), 0);
        send(LD, 1, 2, 0, 0, 1, 0, 0, HIT, 0);
        chk("R12 new req", int'(c_v), 1);
    endtask

    task automatic t_link_clr();
        link_clr = 1'b1;
        @(negedge clk);
        link_clr = 1'b0;
        chk("R9 link clr", int'(link_bit), 0);
        alloc(3);
        send(SC, 3, 0, 5, 0, 1, 0, 0, HIT, 0);
        chk("R9 sc after clr", int'(c_v), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefetch();
        t_sc_nolink();
        t_classes();
        t_pend();
        t_busy();
        t_miss();
        t_stalled();
        t_scfail();
        t_reason();
        t_alloc();
        t_link_clr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R13 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule